// File: doc/BRIEF.md
# Double-Clocked Four-Port Scratchpad Front End

This block sits between a vector core and one dual-port on-chip RAM. The RAM is clocked at twice the core rate, so each core cycle holds two memory cycles. In the first half both physical ports serve operand reads. In the second half one port takes the vector result write and the other serves the DMA channel to off-chip memory. The core therefore sees two read ports, one write port and one DMA port, all backed by a single copy of the data.

Elements are stored at their natural width of 8, 16 or 32 bits. A vector write carries the element in the low bits of its data bus. The block places it on the correct byte lanes of the addressed word and raises only those byte enables, so the rest of the word is left alone. The DMA port always moves whole words. The fast clock must be phase-aligned to the core clock, with its rising edges falling on every core rising edge and in the middle of each core cycle. A toggle register that crosses from the core clock into the fast clock tells the two halves apart. `rst_n` is asynchronous, active low and is released synchronously to `clk_core`.

Top module: `sp_quad_port`

## Requirements
- R1: While `rst_n` is low, `rd_a_data`, `rd_b_data` and `dma_rdata` are all zero.
- R2: Operand port A returns the word that holds byte address `rd_a_addr` (the low two address bits select nothing). Port B does the same with `rd_b_addr`. The data for addresses presented in core cycle n is on the outputs after the rising edge that ends cycle n and holds for one cycle.
- R3: A write with `wr_en` high stores an element whose width is set by `wr_size`: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits. The element is taken from the low bits of `wr_data`. A byte goes to lane `wr_addr[1:0]` (lane k is bits 8k+7..8k). A halfword goes to lanes 0-1 when `wr_addr[1]` is 0 and to lanes 2-3 when it is 1, and `wr_addr[0]` is ignored. A word ignores `wr_addr[1:0]`. The bytes of the word that the element does not cover keep their values.
- R4: A write with `wr_size` = 3 changes nothing in memory.
- R5: Operand reads are carried out in the first half of the core cycle, and the vector write and DMA access in the second half. A read of a word that is written in the same core cycle therefore returns the old contents, and a read in the next cycle returns the new contents.
- R6: With `dma_en` high, `dma_we` high writes the whole `dma_wdata` word to word address `dma_addr`. `dma_we` low reads that word. For a read in cycle n, the word is on `dma_rdata` after the rising edge that ends cycle n+1.
- R7: A DMA read of a word that receives a vector write in the same cycle returns the contents from before that write.
- R8: When a vector write and a DMA write hit the same word in the same cycle, the word afterwards equals the DMA data in all bytes.
- R9: With `wr_en` low, or `dma_en` low, the corresponding port writes nothing, whatever its address, size and data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Vector-core clock |
| clk_mem | input | 1 | RAM clock, twice the core rate, rising edges aligned to `clk_core` |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_addr | input | ADDR_W | Byte address of operand A |
| rd_b_addr | input | ADDR_W | Byte address of operand B |
| rd_a_data | output | DATA_W | Operand A word, one core cycle after its address |
| rd_b_data | output | DATA_W | Operand B word, one core cycle after its address |
| wr_en | input | 1 | Vector result write request |
| wr_addr | input | ADDR_W | Byte address of the result element |
| wr_size | input | 2 | Element width code: 0 byte, 1 halfword, 2 word, 3 no write |
| wr_data | input | DATA_W | Result element, low-bit justified |
| dma_en | input | 1 | DMA access request |
| dma_we | input | 1 | DMA direction: 1 write, 0 read |
| dma_addr | input | ADDR_W-2 | DMA word address |
| dma_wdata | input | DATA_W | DMA write word |
| dma_rdata | output | DATA_W | DMA read word, two core edges after the request |

## Verification
The hardest situation to reach is a single core cycle in which one word is read by an operand port, written by the vector port and accessed by DMA. Only this case shows whether the two half-cycles run in the right order and which write takes priority. The bench builds these collisions on purpose: it points an operand read and a DMA read at the word being written, and it issues a byte write and a DMA write to the same word in one cycle. It also sweeps every element width against every low-address offset over all words. A long pseudo-random run then mixes all four ports, checking against a word-array model whose two-edge DMA latency is tracked separately.

// File: rtl/sp_pkg.sv
package sp_pkg;
  // element width codes carried on wr_size
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } elem_size_e;
endpackage

// File: rtl/sp_phase.sv
// Identifies the two halves of a core cycle in the fast clock domain.
// A core-domain toggle is compared with its fast-domain copy; they differ
// during the first half of every core cycle.
module sp_phase (
  input  logic clk_core,
  input  logic clk_mem,
  input  logic rst_n,
  output logic ph0
);
  logic tog, tog_d;
  logic tog_q, tog_q_d;

  always_comb begin
    tog_d   = ~tog;
    tog_q_d = tog;
  end

  always_ff @(posedge clk_core or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= tog_d;
  end

  always_ff @(posedge clk_mem or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_q_d;
  end

  assign ph0 = tog ^ tog_q;
endmodule

// File: rtl/sp_lane_enc.sv
// Places a low-justified element on its byte lanes and builds byte enables.
module sp_lane_enc #(
  parameter  int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int LSB    = $clog2(NB)
) (
  input  logic              en,
  input  logic [1:0]        size,
  input  logic [LSB-1:0]    addr_lo,
  input  logic [DATA_W-1:0] data,
  output logic [NB-1:0]     be,
  output logic [DATA_W-1:0] wdata
);
  always_comb begin
    int sz;
    int lo;
    sz    = int'(size);
    lo    = int'(addr_lo);
    be    = '0;
    wdata = '0;
    for (int i = 0; i < NB; i++) begin
      // replicate the element across lanes of its own width
      wdata[8*i +: 8] = data[8*(i & ((1 << sz) - 1)) +: 8];
      // lanes belonging to the addressed element slot
      if (en && (sz <= LSB) && (sz != int'(sp_pkg::SZ_NONE)) && ((i >> sz) == (lo >> sz)))
        be[i] = 1'b1;
    end
  end
endmodule

// File: rtl/sp_ram2p.sv
// Two-port RAM, read-before-write on each port; port B write lands last.
module sp_ram2p #(
  parameter  int DATA_W = 32,
  parameter  int WA_W   = 8,
  localparam int NB     = DATA_W / 8,
  localparam int DEPTH  = 1 << WA_W
) (
  input  logic              clk,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [NB-1:0]     a_be,
  input  logic [WA_W-1:0]   a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_q,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [NB-1:0]     b_be,
  input  logic [WA_W-1:0]   b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en && !a_we) a_q <= mem[a_addr];
    if (b_en && !b_we) b_q <= mem[b_addr];
    for (int i = 0; i < NB; i++) begin
      if (a_en && a_we && a_be[i]) mem[a_addr][8*i +: 8] <= a_wdata[8*i +: 8];
    end
    for (int i = 0; i < NB; i++) begin
      if (b_en && b_we && b_be[i]) mem[b_addr][8*i +: 8] <= b_wdata[8*i +: 8];
    end
  end
endmodule

// File: rtl/sp_quad_port.sv
module sp_quad_port #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                                clk_core,
  input  logic                                clk_mem,
  input  logic                                rst_n,
  input  logic [ADDR_W-1:0]                   rd_a_addr,
  input  logic [ADDR_W-1:0]                   rd_b_addr,
  output logic [DATA_W-1:0]                   rd_a_data,
  output logic [DATA_W-1:0]                   rd_b_data,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [1:0]                          wr_size,
  input  logic [DATA_W-1:0]                   wr_data,
  input  logic                                dma_en,
  input  logic                                dma_we,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]  dma_addr,
  input  logic [DATA_W-1:0]                   dma_wdata,
  output logic [DATA_W-1:0]                   dma_rdata
);
  localparam int NB   = DATA_W / 8;
  localparam int LSB  = $clog2(NB);
  localparam int WA_W = ADDR_W - LSB;

  logic              ph0;
  logic [NB-1:0]     wbe;
  logic [DATA_W-1:0] wword;

  logic              a_en, a_we, b_en, b_we;
  logic [WA_W-1:0]   a_addr, b_addr;
  logic [DATA_W-1:0] a_q, b_q;

  logic [DATA_W-1:0] dma_hold, dma_hold_d;
  logic [DATA_W-1:0] rd_a_d, rd_b_d, dma_rd_d;

  sp_phase u_phase (
    .clk_core (clk_core),
    .clk_mem  (clk_mem),
    .rst_n    (rst_n),
    .ph0      (ph0)
  );

  sp_lane_enc #(.DATA_W(DATA_W)) u_lane (
    .en      (wr_en),
    .size    (wr_size),
    .addr_lo (wr_addr[LSB-1:0]),
    .data    (wr_data),
    .be      (wbe),
    .wdata   (wword)
  );

  // first half: both ports read operands; second half: write and DMA
  always_comb begin
    a_we   = !ph0 && (|wbe);
    a_en   = ph0 || a_we;
    a_addr = ph0 ? rd_a_addr[ADDR_W-1:LSB] : wr_addr[ADDR_W-1:LSB];
    b_we   = !ph0 && dma_en && dma_we;
    b_en   = ph0 || dma_en;
    b_addr = ph0 ? rd_b_addr[ADDR_W-1:LSB] : dma_addr;
  end

  sp_ram2p #(.DATA_W(DATA_W), .WA_W(WA_W)) u_ram (
    .clk     (clk_mem),
    .a_en    (a_en),
    .a_we    (a_we),
    .a_be    (wbe),
    .a_addr  (a_addr),
    .a_wdata (wword),
    .a_q     (a_q),
    .b_en    (b_en),
    .b_we    (b_we),
    .b_be    ({NB{1'b1}}),
    .b_addr  (b_addr),
    .b_wdata (dma_wdata),
    .b_q     (b_q)
  );

  // DMA result is parked on the following first-half edge, before port B
  // is reused for an operand
  always_comb begin
    dma_hold_d = ph0 ? b_q : dma_hold;
  end

  always_ff @(posedge clk_mem or negedge rst_n) begin
    if (!rst_n) dma_hold <= '0;
    else        dma_hold <= dma_hold_d;
  end

  always_comb begin
    rd_a_d   = a_q;
    rd_b_d   = b_q;
    dma_rd_d = dma_hold;
  end

  always_ff @(posedge clk_core or negedge rst_n) begin
    if (!rst_n) begin
      rd_a_data <= '0;
      rd_b_data <= '0;
      dma_rdata <= '0;
    end else begin
      rd_a_data <= rd_a_d;
      rd_b_data <= rd_b_d;
      dma_rdata <= dma_rd_d;
    end
  end
endmodule

// File: rtl/sp_quad_port_chk.sv
module sp_quad_port_chk #(
  parameter int NB = 4
) (
  input logic          clk_core,
  input logic          clk_mem,
  input logic          rst_n,
  input logic          ph0,
  input logic          wr_en,
  input logic [1:0]    wr_size,
  input logic [NB-1:0] wbe,
  input logic          a_we,
  input logic          b_we
);
  // R5: a first half is always followed by a second half
  a_r5_phase_alt: assert property (@(posedge clk_mem) disable iff (!rst_n)
    ph0 |=> !ph0);

  // R5: every core edge closes a second half
  a_r5_core_edge: assert property (@(posedge clk_core) disable iff (!rst_n)
    !ph0);

  // R5: RAM writes never happen on a read edge
  a_r5_write_late: assert property (@(posedge clk_mem) disable iff (!rst_n)
    (a_we || b_we) |-> !ph0);

  // R3: byte write touches one lane
  a_r3_byte_lane: assert property (@(posedge clk_core) disable iff (!rst_n)
    (wr_en && wr_size == 2'd0) |-> $countones(wbe) == 1);

  // R3: halfword write covers an aligned lane pair
  a_r3_half_lanes: assert property (@(posedge clk_core) disable iff (!rst_n)
    (wr_en && wr_size == 2'd1) |-> (wbe == 4'b0011 || wbe == 4'b1100));

  // R3: word write covers all lanes
  a_r3_word_lanes: assert property (@(posedge clk_core) disable iff (!rst_n)
    (wr_en && wr_size == 2'd2) |-> wbe == 4'b1111);

  // R4, R9: reserved size or idle port gives no enables
  a_r4_no_lanes: assert property (@(posedge clk_core) disable iff (!rst_n)
    (!wr_en || wr_size == 2'd3) |-> wbe == '0);
endmodule

bind sp_quad_port sp_quad_port_chk #(.NB(NB)) u_chk (
  .clk_core (clk_core),
  .clk_mem  (clk_mem),
  .rst_n    (rst_n),
  .ph0      (ph0),
  .wr_en    (wr_en),
  .wr_size  (wr_size),
  .wbe      (wbe),
  .a_we     (a_we),
  .b_we     (b_we)
);

// File: tb/sp_quad_port_bench.sv
`timescale 1ns/1ps
module sp_quad_port_bench;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int WW = 8;
  localparam int NW = 256;

  logic clk_core, clk_mem, rst_n;
  logic [AW-1:0] rd_a_addr, rd_b_addr, wr_addr;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data, dma_wdata, dma_rdata;
  logic          wr_en, dma_en, dma_we;
  logic [1:0]    wr_size;
  logic [WW-1:0] dma_addr;

  sp_quad_port #(.ADDR_W(AW), .DATA_W(DW)) u_sp_quad_port (
    .clk_core(clk_core), .clk_mem(clk_mem), .rst_n(rst_n),
    .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
    .dma_en(dma_en), .dma_we(dma_we), .dma_addr(dma_addr),
    .dma_wdata(dma_wdata), .dma_rdata(dma_rdata)
  );

  // one process drives both clocks so their edges coincide; core = 100 MHz
  initial begin
    clk_mem  = 1'b0;
    clk_core = 1'b0;
    forever begin
      #2.5 clk_mem = ~clk_mem;
      if (clk_mem) clk_core = ~clk_core;
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [DW-1:0] mdl [NW];
  bit            known [NW];

  bit            pend_v = 0;
  logic [DW-1:0] pend_val;
  string         pend_rq;

  task automatic chk(string rq, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [AW-1:0] a,
                                          logic [1:0] sz, logic [DW-1:0] d);
    logic [DW-1:0] r;
    r = old;
    case (sz)
      2'd0: r[8*a[1:0] +: 8] = d[7:0];
      2'd1: r[16*a[1] +: 16] = d[15:0];
      2'd2: r = d;
      default: r = old;
    endcase
    return r;
  endfunction

  // one core cycle: drive, predict, advance model, step, check
  task automatic run(string rq,
                     logic [AW-1:0] ra, logic [AW-1:0] rb,
                     logic we, logic [AW-1:0] wa, logic [1:0] ws, logic [DW-1:0] wd,
                     logic de, logic dw, logic [WW-1:0] da, logic [DW-1:0] dd);
    logic [DW-1:0] ea, eb;
    bit            ka, kb, nv;
    logic [DW-1:0] nval;
    int            ww;
    rd_a_addr = ra; rd_b_addr = rb;
    wr_en = we; wr_addr = wa; wr_size = ws; wr_data = wd;
    dma_en = de; dma_we = dw; dma_addr = da; dma_wdata = dd;
    ea = mdl[ra[AW-1:2]]; ka = known[ra[AW-1:2]];
    eb = mdl[rb[AW-1:2]]; kb = known[rb[AW-1:2]];
    nv = de && !dw && known[da];
    nval = mdl[da];
    ww = int'(wa[AW-1:2]);
    if (we) mdl[ww] = merge(mdl[ww], wa, ws, wd);
    if (de && dw) begin mdl[da] = dd; known[da] = 1; end
    @(posedge clk_core); #1;
    if (ka) chk(rq, "operand A", rd_a_data, ea);
    if (kb) chk(rq, "operand B", rd_b_data, eb);
    if (pend_v) chk(pend_rq, "DMA read", dma_rdata, pend_val);
    pend_v = nv; pend_val = nval; pend_rq = rq;
  endtask

  task automatic idle(string rq, logic [AW-1:0] ra, logic [AW-1:0] rb);
    run(rq, ra, rb, 0, '0, 2'd0, '0, 0, 0, '0, '0);
  endtask

  function automatic logic [DW-1:0] pat(int w);
    return (32'(w) * 32'h01020304) ^ 32'hC3A5_0000;
  endfunction

  initial begin
    logic [31:0] x;
    rst_n = 1'b0;
    rd_a_addr = '0; rd_b_addr = '0; wr_en = 0; wr_addr = '0; wr_size = '0;
    wr_data = '0; dma_en = 0; dma_we = 0; dma_addr = '0; dma_wdata = '0;
    for (int i = 0; i < NW; i++) known[i] = 0;
    repeat (3) @(posedge clk_core);
    #1;
    chk("R1", "reset A", rd_a_data, '0);
    chk("R1", "reset B", rd_b_data, '0);
    chk("R1", "reset DMA", dma_rdata, '0);
    rst_n = 1'b1;

    // R6: fill every word over DMA
    for (int w = 0; w < NW; w++) run("R6", '0, '0, 0, '0, 2'd0, '0, 1, 1, WW'(w), pat(w));
    // R2: read every word on both operand ports
    for (int w = 0; w < NW; w++) idle("R2", AW'(w*4 + (w & 3)), AW'((NW-1-w)*4));
    // R6: read every word over DMA
    for (int w = 0; w < NW; w++) run("R6", '0, '0, 0, '0, 2'd0, '0, 1, 0, WW'(w), '0);
    idle("R6", '0, '0);

    // R3/R4: every size against every offset, each on its own block of words;
    // operand A reads the word being written, B the previous write
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        for (int k = 0; k < 16; k++) begin
          int w;
          w = (s*4 + o)*16 + k;
          run(s == 3 ? "R4" : "R3", AW'(w*4), AW'((w == 0 ? 0 : w-1)*4),
              1, AW'(w*4 + o), 2'(s), 32'h9E37_79B9 ^ 32'(w*7919), 0, 0, '0, '0);
        end
    for (int w = 0; w < NW; w++) idle((w >= 192) ? "R4" : "R3", AW'(w*4), AW'(w*4));

    // R5: same-cycle read sees old word, next cycle sees new
    run("R5", AW'(5*4), AW'(5*4), 1, AW'(5*4), 2'd2, 32'hDEAD_BEEF, 0, 0, '0, '0);
    idle("R5", AW'(5*4), AW'(5*4));
    // R7: DMA read collides with vector write
    run("R7", '0, '0, 1, AW'(9*4+2), 2'd0, 32'h0000_0077, 1, 0, WW'(9), '0);
    idle("R7", AW'(9*4), '0);
    idle("R7", '0, '0);
    // R8: vector write and DMA write on one word
    run("R8", '0, '0, 1, AW'(12*4+1), 2'd0, 32'h0000_00EE, 1, 1, WW'(12), 32'h1234_5678);
    idle("R8", AW'(12*4), AW'(12*4));
    chk("R8", "DMA wins", rd_a_data, 32'h1234_5678);
    // R9: idle ports with busy data inputs
    rd_a_addr = '0;
    run("R9", '0, '0, 0, AW'(20*4), 2'd2, 32'hFFFF_FFFF, 0, 1, WW'(21), 32'hFFFF_FFFF);
    idle("R9", AW'(20*4), AW'(21*4));
    chk("R9", "word 20 kept", rd_a_data, mdl[20]);
    chk("R9", "word 21 kept", rd_b_data, mdl[21]);

    // R2: pseudo-random mix of all four ports
    x = 32'h1357_9BDF;
    for (int c = 0; c < 3000; c++) begin
      logic [31:0] y;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      y = x * 32'h2545_F491;
      run("R2", AW'(x[9:0]), AW'(x[19:10]), x[20], AW'(y[9:0]), y[11:10], y,
          x[21], x[22], WW'(y[19:12] ^ x[31:24]), ~y);
    end
    idle("R6", '0, '0);
    idle("R6", '0, '0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule